// File: doc/BRIEF.md
# Debounced Edge Interrupt Bank for General-Purpose Inputs

This block watches a bank of general-purpose input pins and raises one interrupt request when any pin shows a qualified edge that software has asked to be told about. Each raw pin is first brought into the clock domain by two flops. The synchronised value is then sampled on an enable that fires once every four system clocks. A pin's qualified level changes only after the pin has held the new value for a minimum run of consecutive sample ticks. Short pulses therefore cannot create or hide an edge.

Software chooses, per pin, whether rising transitions, falling transitions, or both are of interest. It does so through separate set and clear addresses, where every 1 in the written word acts on its own bit and every 0 leaves its bit alone. Recognised edges of an enabled direction are latched in a sticky per-pin status word. Writing 1 to a status bit clears it. The status bits are OR-combined, gated by a bank-level enable input, into one registered interrupt output.

Top module: `gpio_edge_bank`

## Requirements
- R1: The pins are sampled only on an enable that is high for one system clock in every 4. As a result, a pin change cannot show up in the status word within 5 clocks of reaching the pin.
- R2: A rising edge is recognised only when the synchronised pin was sampled low on at least 2 consecutive ticks and is then sampled high on at least 2 consecutive ticks.
- R3: A falling edge follows the same rule with the levels swapped: at least 2 ticks high, then at least 2 ticks low.
- R4: A pulse that lasts fewer than 2 sample ticks produces no edge and leaves the qualified level as it was. A later real transition in the same direction is still recognised.
- R5: Rising enables are written at address 0x00 (write-one-to-set) and at address 0x04 (write-one-to-clear). Bit i acts on pin i. Zero bits leave their enable unchanged. A read at either address returns the rising-enable word.
- R6: Falling enables use the same scheme at address 0x08 (set) and address 0x0C (clear). A read at either address returns the falling-enable word.
- R7: The status word at address 0x10 sets bit i when pin i has a recognised edge whose direction is enabled. The bit stays set until 1 is written to it there. If an edge and a clear reach the same bit in the same cycle, the bit ends up set.
- R8: `bank_irq` is registered. One cycle after a given state, it equals the AND of `bank_irq_en` with the OR of all status bits in that state.
- R9: After reset, all enables, all status bits and `bank_irq` are 0. The first qualification of each pin after reset sets its level without reporting an edge.
- R10: `bus_rdata` is registered. It reflects the address presented in the previous cycle, and it returns 0 for any address outside the five listed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 16 | Raw asynchronous pin levels, bit i is pin i |
| bank_irq_en | input | 1 | Bank-level gate for the interrupt output |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 16 | Write data, one bit per pin |
| bus_rdata | output | 16 | Registered read data |
| bank_irq | output | 1 | Combined bank interrupt request |

## Verification
The assertions assume that `pin_in` may change at any time but that `bus_wr` is a single-cycle strobe carrying a stable address and data. They also assume that reset is held for at least one clock, so that the divider and qualifier state start from known values. The stimulus changes pins and bus signals only on falling clock edges. It holds each intended level for 16 clocks, which always spans at least two sample ticks, and it makes glitches 3 clocks wide so that they can fall on at most one tick.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int REG_AW = 5;
  localparam logic [REG_AW-1:0] A_RISE_SET = 5'h00;
  localparam logic [REG_AW-1:0] A_RISE_CLR = 5'h04;
  localparam logic [REG_AW-1:0] A_FALL_SET = 5'h08;
  localparam logic [REG_AW-1:0] A_FALL_CLR = 5'h0C;
  localparam logic [REG_AW-1:0] A_STATUS   = 5'h10;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10
  } edge_kind_e;
endpackage

// File: rtl/gpio_tick_gen.sv
module gpio_tick_gen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (cnt == CW'(DIV - 1)) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign tick = !rst && (cnt == CW'(DIV - 1));

  // R1
  tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/gpio_pin_qual.sv
module gpio_pin_qual #(
  parameter int MIN_TICKS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic pin_raw,
  output logic level,
  output logic rise,
  output logic fall
);
  localparam int CW = $clog2(MIN_TICKS + 1);

  logic          sync1, sync2;
  logic          last_smp;
  logic [CW-1:0] run_cnt;
  logic [CW-1:0] run_nx;
  logic          valid;
  logic          qualified;

  always_comb begin
    if (sync2 == last_smp && run_cnt != '0) begin
      run_nx = (run_cnt == CW'(MIN_TICKS)) ? run_cnt : run_cnt + 1'b1;
    end else begin
      run_nx = CW'(1);
    end
    qualified = (run_nx >= CW'(MIN_TICKS));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1    <= 1'b0;
      sync2    <= 1'b0;
      last_smp <= 1'b0;
      run_cnt  <= '0;
      valid    <= 1'b0;
      level    <= 1'b0;
      rise     <= 1'b0;
      fall     <= 1'b0;
    end else begin
      sync1 <= pin_raw;
      sync2 <= sync1;
      rise  <= 1'b0;
      fall  <= 1'b0;
      if (tick) begin
        last_smp <= sync2;
        run_cnt  <= run_nx;
        if (qualified && (!valid || level != sync2)) begin
          level <= sync2;
          valid <= 1'b1;
          rise  <= valid && sync2;
          fall  <= valid && !sync2;
        end
      end
    end
  end

  // R2
  rise_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    rise |-> ($past(tick) && level));
  // R3
  fall_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    fall |-> ($past(tick) && !level));
  // R4
  level_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(level));
  // R2
  one_edge_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rise, fall}));
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_pkg::*;
#(
  parameter int N_PINS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_PINS-1:0] rise_evt,
  input  logic [N_PINS-1:0] fall_evt,
  input  logic              bank_en,
  input  logic              wr,
  input  logic [REG_AW-1:0] addr,
  input  logic [N_PINS-1:0] wdata,
  output logic [N_PINS-1:0] rdata,
  output logic              irq
);
  logic [N_PINS-1:0] rise_en, fall_en, status;
  logic [N_PINS-1:0] hit, clr_mask, status_nx;

  assign hit       = (rise_evt & rise_en) | (fall_evt & fall_en);
  assign clr_mask  = (wr && addr == A_STATUS) ? wdata : '0;
  assign status_nx = (status & ~clr_mask) | hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_en <= '0;
      fall_en <= '0;
      status  <= '0;
      irq     <= 1'b0;
      rdata   <= '0;
    end else begin
      if (wr) begin
        case (addr)
          A_RISE_SET: rise_en <= rise_en | wdata;
          A_RISE_CLR: rise_en <= rise_en & ~wdata;
          A_FALL_SET: fall_en <= fall_en | wdata;
          A_FALL_CLR: fall_en <= fall_en & ~wdata;
          default: ;
        endcase
      end
      status <= status_nx;
      irq    <= bank_en && (|status);
      case (addr)
        A_RISE_SET, A_RISE_CLR: rdata <= rise_en;
        A_FALL_SET, A_FALL_CLR: rdata <= fall_en;
        A_STATUS:               rdata <= status;
        default:                rdata <= '0;
      endcase
    end
  end

  // R5
  rise_set_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == A_RISE_SET) |=> ((rise_en & $past(wdata)) == $past(wdata)));
  // R5
  rise_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == A_RISE_CLR) |=> ((rise_en & $past(wdata)) == '0));
  // R6
  fall_set_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == A_FALL_SET) |=> ((fall_en & $past(wdata)) == $past(wdata)));
  // R7
  edge_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (hit != '0) |=> ((status & $past(hit)) == $past(hit)));
  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(bank_en));
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
  import gpio_pkg::*;
#(
  parameter int N_PINS    = 16,
  parameter int DIV       = 4,
  parameter int MIN_TICKS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_PINS-1:0] pin_in,
  input  logic              bank_irq_en,
  input  logic              bus_wr,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [N_PINS-1:0] bus_wdata,
  output logic [N_PINS-1:0] bus_rdata,
  output logic              bank_irq
);
  logic              smp_tick;
  logic [N_PINS-1:0] q_level, q_rise, q_fall;

  gpio_tick_gen #(.DIV(DIV)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .tick (smp_tick)
  );

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    gpio_pin_qual #(.MIN_TICKS(MIN_TICKS)) u_qual (
      .clk     (clk),
      .rst     (rst),
      .tick    (smp_tick),
      .pin_raw (pin_in[i]),
      .level   (q_level[i]),
      .rise    (q_rise[i]),
      .fall    (q_fall[i])
    );
  end

  gpio_bank_regs #(.N_PINS(N_PINS)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .rise_evt (q_rise),
    .fall_evt (q_fall),
    .bank_en  (bank_irq_en),
    .wr       (bus_wr),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .rdata    (bus_rdata),
    .irq      (bank_irq)
  );

  // R9
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!bank_irq && bus_rdata == '0));
endmodule

// File: tb/tb_gpio_edge_bank.sv
module tb_gpio_edge_bank;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] pin_in;
  logic        bank_irq_en;
  logic        bus_wr;
  logic [4:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        bank_irq;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  gpio_edge_bank dut (
    .clk(clk), .rst(rst), .pin_in(pin_in), .bank_irq_en(bank_irq_en),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bank_irq(bank_irq)
  );

  // {pins, hold cycles, expected status}; rising enabled on 0x00FF, falling on 0xFF00
  localparam logic [39:0] VEC [0:5] = '{
    {16'h0001, 8'd16, 16'h0001},  // R2 rising, enabled
    {16'h0000, 8'd16, 16'h0000},  // R3 falling, not enabled
    {16'h0100, 8'd16, 16'h0000},  // R2 rising, not enabled
    {16'h0000, 8'd16, 16'h0100},  // R3 falling, enabled
    {16'h8081, 8'd16, 16'h0081},  // R7 several pins at once
    {16'h0000, 8'd16, 16'h8000}   // R3 mixed falls
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    wait_cyc(3);
    rst = 1'b0;
    wait_cyc(20);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] v;
    pin_in = '0; bank_irq_en = 1'b1; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    do_reset();

    // R9 reset state
    check("R9 irq after reset", {15'd0, bank_irq}, 16'h0);
    rd(5'h00, v); check("R9 rise enables", v, 16'h0);
    rd(5'h08, v); check("R9 fall enables", v, 16'h0);
    rd(5'h10, v); check("R9 status", v, 16'h0);

    // R5 / R6 write-one-to-set and -clear
    wr(5'h00, 16'h0003); rd(5'h04, v); check("R5 set rise", v, 16'h0003);
    wr(5'h04, 16'h0001); rd(5'h00, v); check("R5 clear rise keeps others", v, 16'h0002);
    wr(5'h04, 16'hFFFF); wr(5'h00, 16'h00FF); rd(5'h00, v); check("R5 rise word", v, 16'h00FF);
    wr(5'h08, 16'hFF01); wr(5'h0C, 16'h0001); rd(5'h0C, v); check("R6 fall word", v, 16'hFF00);
    rd(5'h14, v); check("R10 unmapped read", v, 16'h0);

    // R1 no detection within 5 clocks, then detection
    @(negedge clk); pin_in = 16'h0002;
    wait_cyc(3); rd(5'h10, v); check("R1 early status", v, 16'h0);
    wait_cyc(16); rd(5'h10, v); check("R1 later status", v, 16'h0002);
    wr(5'h10, 16'hFFFF); rd(5'h10, v); check("R7 write-one clears", v, 16'h0);
    @(negedge clk); pin_in = 16'h0000; wait_cyc(16);
    rd(5'h10, v); check("R3 disabled fall", v, 16'h0);

    // table
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); pin_in = VEC[k][39:24];
      wait_cyc(int'(VEC[k][23:16]));
      rd(5'h10, v); check($sformatf("R7 vector %0d", k), v, VEC[k][15:0]);
      wait_cyc(2);
      check($sformatf("R8 irq vector %0d", k), {15'd0, bank_irq}, {15'd0, |VEC[k][15:0]});
      wr(5'h10, 16'hFFFF);
    end

    // R4 glitch ignored, level unchanged
    @(negedge clk); pin_in = 16'h0004;
    wait_cyc(3); pin_in = 16'h0000;
    wait_cyc(20); rd(5'h10, v); check("R4 glitch no edge", v, 16'h0);
    @(negedge clk); pin_in = 16'h0004; wait_cyc(16);
    rd(5'h10, v); check("R4 later rise seen", v, 16'h0004);

    // R7 sticky, R8 gating
    wait_cyc(10); rd(5'h10, v); check("R7 sticky", v, 16'h0004);
    bank_irq_en = 1'b0; wait_cyc(3);
    check("R8 gated off", {15'd0, bank_irq}, 16'h0);
    bank_irq_en = 1'b1; wait_cyc(3);
    check("R8 gated on", {15'd0, bank_irq}, 16'h1);
    wr(5'h10, 16'h0004); wait_cyc(3);
    check("R8 irq drops", {15'd0, bank_irq}, 16'h0);

    // R9 first qualification after reset gives no edge
    pin_in = 16'h00FF;
    do_reset();
    wr(5'h00, 16'hFFFF); wr(5'h08, 16'hFFFF);
    wait_cyc(16); rd(5'h10, v); check("R9 no initial edge", v, 16'h0);
    @(negedge clk); pin_in = 16'h00F0; wait_cyc(16);
    rd(5'h10, v); check("R3 fall after reset", v, 16'h000F);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule